// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Unit

This block sits next to a small 8-bit processor core and gives a debugger two things. The first is a set of address comparators that watch the instruction fetch bus and the shared data access bus. That data bus carries internal data, external data and special-register accesses, each tagged by its space. The second is a run-control state machine that can stop the core, let it run, let it run one instruction, or tell it to skip one instruction. A comparator that matches an access raises a one-cycle hit pulse, sets a sticky status and asks the core to stop. The core is never stopped in the middle of an instruction; it stops at the next instruction-complete strobe.

Each of the four comparator entries holds an enable, a space selector, a read/write qualifier, a 24-bit address, an 8-bit data pattern and a data-compare enable. An entry on the code space works as a breakpoint on fetch addresses. An entry on a data space works as a breakpoint on addresses. With its data compare enabled, it works as a watchpoint on a specific value. Commands and entry writes arrive on a plain register-style port.

Until the debugger switches the unit on, the comparators are held off and the core runs freely. Switching the unit off again releases a stopped core.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset, cpu_hold, cpu_skip, hit_pulse, hit_sticky and debug_access are 0, code_running is 1, and the unit is switched off.
- R2: When the unit is on, a fetch whose address equals the address of an enabled entry with space 0 (code) sets hit_pulse for exactly one cycle, in the cycle after the fetch. In that cycle, pulse_index gives the entry number.
- R3: An entry on a data space matches a read only if rw bit 0 is set, and matches a write only if rw bit 1 is set (mem_we=1 marks a write).
- R4: With dmatch_en=1, an entry also needs mem_wdata to equal its data pattern. With dmatch_en=0, the data on the bus is ignored.
- R5: The space codes are 1 for internal data, 2 for external data and 3 for special registers. An access matches only entries whose space code equals mem_space, and a fetch never matches a data-space entry.
- R6: A disabled entry never matches. When several entries match at once, pulse_index reports the lowest entry number.
- R7: hit_sticky is set by a hit and sticky_index keeps the entry number of the first hit until a CLEAR command (op 5). A hit in the same cycle as CLEAR leaves the status set, with the new index.
- R8: A hit or a HALT command (op 1) that arrives while the core runs makes cpu_hold rise only after the next instr_done that comes after the request was registered. code_running is always the inverse of cpu_hold.
- R9: A RUN command (op 2) while the core is held drops cpu_hold in the next cycle.
- R10: A STEP command (op 3) while the core is held drops cpu_hold. cpu_hold rises again after exactly one instr_done.
- R11: A SKIP command (op 4) while the core is held drops cpu_hold and raises cpu_skip. After the next instr_done, cpu_skip is 0 and cpu_hold is 1.
- R12: ON (op 6) and OFF (op 7) switch the unit. While it is off, no access produces a hit and every other command is ignored. OFF releases a held core.
- R13: While the unit is on, debug_access follows host_acc with one cycle of delay. While the unit is off, debug_access stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| ent_we | input | 1 | Entry write strobe |
| ent_sel | input | 2 | Entry number to write |
| ent_en | input | 1 | Entry enable |
| ent_space | input | 2 | Entry space code |
| ent_rw | input | 2 | Read/write qualifier (bit0 read, bit1 write) |
| ent_addr | input | 24 | Entry address |
| ent_data | input | 8 | Entry data pattern |
| ent_dmen | input | 1 | Entry data compare enable |
| fetch_valid | input | 1 | Instruction fetch in this cycle |
| fetch_addr | input | 24 | Fetch address |
| mem_valid | input | 1 | Data access in this cycle |
| mem_space | input | 2 | Space code of the data access |
| mem_we | input | 1 | Data access is a write |
| mem_addr | input | 24 | Data access address |
| mem_wdata | input | 8 | Data value on the access bus |
| instr_done | input | 1 | Instruction-complete strobe from the core |
| host_acc | input | 1 | Debugger memory access in progress |
| cpu_hold | output | 1 | Hold the core at the instruction boundary |
| cpu_skip | output | 1 | Skip the current instruction |
| code_running | output | 1 | Core is executing |
| debug_access | output | 1 | Debugger access status |
| hit_pulse | output | 1 | One-cycle hit indication |
| pulse_index | output | 2 | Entry number of the current hit |
| hit_sticky | output | 1 | Sticky hit status |
| sticky_index | output | 2 | Entry number of the first hit since clear |

## Verification
The comparators are driven with fetches and data accesses that each differ from a matching entry in one field only: the space, the direction, the data value, or the enable. A missing hit on one of these points to a specific term of the match. Overlapping entries separate the priority encoder from the sticky first-hit record. Two hits in a row show that the sticky index keeps the older entry while pulse_index follows the newer one. The run-control sequences place instr_done before and after a registered halt request, and compare step, skip, run and switching the unit off. This shows that the hold rises only at a boundary and that step and skip each let exactly one instruction pass.

// File: rtl/dbg_watch_pkg.sv
// Shared encodings for the debug breakpoint and watchpoint unit.
// Assumes: space and command codes are fixed by the external host protocol.
package dbg_watch_pkg;

    typedef enum logic [1:0] {
        SP_CODE  = 2'd0,
        SP_IDATA = 2'd1,
        SP_XDATA = 2'd2,
        SP_SFR   = 2'd3
    } space_e;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_HALT  = 3'd1,
        OP_RUN   = 3'd2,
        OP_STEP  = 3'd3,
        OP_SKIP  = 3'd4,
        OP_CLEAR = 3'd5,
        OP_ON    = 3'd6,
        OP_OFF   = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        RC_RUN   = 3'd0,
        RC_PEND  = 3'd1,
        RC_HELD  = 3'd2,
        RC_STEP  = 3'd3,
        RC_SKIP  = 3'd4
    } rc_state_e;

endpackage

// File: rtl/dbg_cmp_entry.sv
// One comparator entry: matches a fetch (code space) or a data access
// (idata, xdata, sfr) against its stored address, direction and data pattern.
// Assumes: fetch and data buses are valid only in cycles their strobe is high.
module dbg_cmp_entry
    import dbg_watch_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input  logic              active,
    input  logic              en,
    input  logic [1:0]        space,
    input  logic [1:0]        rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              dmen,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              mem_valid,
    input  logic [1:0]        mem_space,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic              match
);

    logic code_hit;
    logic data_hit;
    logic dir_ok;
    logic val_ok;

    // Evaluate the code-space and data-space match terms for this entry.
    always_comb begin
        code_hit = (space == SP_CODE) && fetch_valid && (fetch_addr == addr);
        dir_ok   = mem_we ? rw[1] : rw[0];
        val_ok   = !dmen || (mem_wdata == data);
        data_hit = (space != SP_CODE) && mem_valid && (mem_space == space)
                   && dir_ok && (mem_addr == addr) && val_ok;
        match    = active && en && (code_hit || data_hit);
    end

endmodule

// File: rtl/dbg_hit_log.sv
// Hit logger: turns the comparator match vector into a one-cycle pulse with
// the lowest matching index, and keeps a sticky record of the first hit.
// Assumes: clr is a single-cycle strobe from run control.
module dbg_hit_log #(
    parameter int NUM_ENT = 4,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic [NUM_ENT-1:0] match,
    input  logic               clr,
    output logic               hit_pulse,
    output logic [IDX_W-1:0]   pulse_index,
    output logic               hit_sticky,
    output logic [IDX_W-1:0]   sticky_index
);

    logic             any_hit;
    logic [IDX_W-1:0] first_idx;

    // Priority-encode the match vector, lowest entry number wins.
    always_comb begin
        any_hit   = active && (|match);
        first_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (match[i]) first_idx = IDX_W'(i);
        end
    end

    // Register the hit pulse and its index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_pulse   <= 1'b0;
            pulse_index <= '0;
        end else begin
            hit_pulse   <= any_hit;
            pulse_index <= any_hit ? first_idx : pulse_index;
        end
    end

    // Keep the sticky record: first hit wins, clear drops it, hit beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_sticky   <= 1'b0;
            sticky_index <= '0;
        end else if (any_hit && (!hit_sticky || clr)) begin
            hit_sticky   <= 1'b1;
            sticky_index <= first_idx;
        end else if (clr && !any_hit) begin
            hit_sticky   <= 1'b0;
        end
    end

    AST_PULSE_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pulse |-> $past(active)); // R12

    AST_STICKY_KEEPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_sticky && !clr) |=> (hit_sticky && $stable(sticky_index))); // R7

    AST_PULSE_SETS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pulse |-> hit_sticky); // R7

endmodule

// File: rtl/dbg_runctl.sv
// Run control: decodes host commands and hit pulses into hold and skip
// controls for the core, releasing or stopping it only at instruction
// boundaries, and keeps the on/off state of the unit.
// Assumes: instr_done is a one-cycle strobe at the end of each instruction.
module dbg_runctl
    import dbg_watch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       hit_pulse,
    input  logic       instr_done,
    output logic       active,
    output logic       cpu_hold,
    output logic       cpu_skip,
    output logic       clr_status
);

    rc_state_e state_q;
    rc_state_e state_d;
    logic      active_d;
    logic      op_halt, op_run, op_step, op_skip, op_on, op_off;

    // Decode the command strobe into single-operation flags.
    always_comb begin
        op_halt    = cmd_valid && (cmd_op == OP_HALT);
        op_run     = cmd_valid && (cmd_op == OP_RUN);
        op_step    = cmd_valid && (cmd_op == OP_STEP);
        op_skip    = cmd_valid && (cmd_op == OP_SKIP);
        op_on      = cmd_valid && (cmd_op == OP_ON);
        op_off     = cmd_valid && (cmd_op == OP_OFF);
        clr_status = active && cmd_valid && (cmd_op == OP_CLEAR);
    end

    // Compute the next run-control state and the next on/off state.
    always_comb begin
        state_d  = state_q;
        active_d = active;
        if (!active) begin
            state_d = RC_RUN;
            if (op_on) active_d = 1'b1;
        end else if (op_off) begin
            active_d = 1'b0;
            state_d  = RC_RUN;
        end else begin
            unique case (state_q)
                RC_RUN:  if (op_halt || hit_pulse) state_d = RC_PEND;
                RC_PEND: if (instr_done) state_d = RC_HELD;
                RC_HELD: begin
                    if (op_run)       state_d = RC_RUN;
                    else if (op_step) state_d = RC_STEP;
                    else if (op_skip) state_d = RC_SKIP;
                end
                RC_STEP: if (instr_done) state_d = RC_HELD;
                RC_SKIP: if (instr_done) state_d = RC_HELD;
                default: state_d = RC_RUN;
            endcase
        end
    end

    // Hold the state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RC_RUN;
            active  <= 1'b0;
        end else begin
            state_q <= state_d;
            active  <= active_d;
        end
    end

    // Drive the core controls from the current state.
    always_comb begin
        cpu_hold = (state_q == RC_HELD);
        cpu_skip = (state_q == RC_SKIP);
    end

    AST_HOLD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_hold) |-> $past(instr_done)); // R8

    AST_STEP_ONE_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RC_STEP && instr_done && active && !op_off) |=> cpu_hold); // R10

    AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_skip |-> !cpu_hold); // R11

    AST_OFF_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!cpu_hold && !cpu_skip)); // R12

endmodule

// File: rtl/dbg_watch_unit.sv
// Top of the debug breakpoint and watchpoint unit: holds the comparator
// entries, instantiates one comparator per entry, the hit logger and the
// run-control machine, and drives the status outputs.
// Assumes: one fetch and one data access at most per cycle.
module dbg_watch_unit #(
    parameter int NUM_ENT = 4,
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              ent_we,
    input  logic [IDX_W-1:0]  ent_sel,
    input  logic              ent_en,
    input  logic [1:0]        ent_space,
    input  logic [1:0]        ent_rw,
    input  logic [ADDR_W-1:0] ent_addr,
    input  logic [DATA_W-1:0] ent_data,
    input  logic              ent_dmen,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              mem_valid,
    input  logic [1:0]        mem_space,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    input  logic              instr_done,
    input  logic              host_acc,
    output logic              cpu_hold,
    output logic              cpu_skip,
    output logic              code_running,
    output logic              debug_access,
    output logic              hit_pulse,
    output logic [IDX_W-1:0]  pulse_index,
    output logic              hit_sticky,
    output logic [IDX_W-1:0]  sticky_index
);

    logic               active;
    logic               clr_status;
    logic [NUM_ENT-1:0] match;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        logic              en_q;
        logic [1:0]        space_q;
        logic [1:0]        rw_q;
        logic [ADDR_W-1:0] addr_q;
        logic [DATA_W-1:0] data_q;
        logic              dmen_q;

        // Store this entry's configuration when it is selected for writing.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q    <= 1'b0;
                space_q <= '0;
                rw_q    <= '0;
                addr_q  <= '0;
                data_q  <= '0;
                dmen_q  <= 1'b0;
            end else if (ent_we && (ent_sel == IDX_W'(g))) begin
                en_q    <= ent_en;
                space_q <= ent_space;
                rw_q    <= ent_rw;
                addr_q  <= ent_addr;
                data_q  <= ent_data;
                dmen_q  <= ent_dmen;
            end
        end

        dbg_cmp_entry #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_cmp (
            .active      (active),
            .en          (en_q),
            .space       (space_q),
            .rw          (rw_q),
            .addr        (addr_q),
            .data        (data_q),
            .dmen        (dmen_q),
            .fetch_valid (fetch_valid),
            .fetch_addr  (fetch_addr),
            .mem_valid   (mem_valid),
            .mem_space   (mem_space),
            .mem_we      (mem_we),
            .mem_addr    (mem_addr),
            .mem_wdata   (mem_wdata),
            .match       (match[g])
        );
    end

    dbg_hit_log #(
        .NUM_ENT (NUM_ENT)
    ) u_log (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (active),
        .match        (match),
        .clr          (clr_status),
        .hit_pulse    (hit_pulse),
        .pulse_index  (pulse_index),
        .hit_sticky   (hit_sticky),
        .sticky_index (sticky_index)
    );

    dbg_runctl u_rc (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .hit_pulse  (hit_pulse),
        .instr_done (instr_done),
        .active     (active),
        .cpu_hold   (cpu_hold),
        .cpu_skip   (cpu_skip),
        .clr_status (clr_status)
    );

    // Register the debugger access status, gated by the on/off state.
    always_ff @(posedge clk) begin
        if (!rst_n) debug_access <= 1'b0;
        else        debug_access <= host_acc && active;
    end

    // Report the core as running whenever it is not held.
    always_comb code_running = !cpu_hold;

    AST_DBGACC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        debug_access |-> $past(host_acc)); // R13

    AST_RUNNING_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        code_running != cpu_hold); // R8

endmodule

// File: tb/dbg_watch_unit_test.sv
`timescale 1ns/1ps
module dbg_watch_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic        ent_we = 1'b0;
    logic [1:0]  ent_sel = '0;
    logic        ent_en = 1'b0;
    logic [1:0]  ent_space = '0;
    logic [1:0]  ent_rw = '0;
    logic [23:0] ent_addr = '0;
    logic [7:0]  ent_data = '0;
    logic        ent_dmen = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [23:0] fetch_addr = '0;
    logic        mem_valid = 1'b0;
    logic [1:0]  mem_space = '0;
    logic        mem_we = 1'b0;
    logic [23:0] mem_addr = '0;
    logic [7:0]  mem_wdata = '0;
    logic        instr_done = 1'b0;
    logic        host_acc = 1'b0;
    logic        cpu_hold, cpu_skip, code_running, debug_access;
    logic        hit_pulse, hit_sticky;
    logic [1:0]  pulse_index, sticky_index;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          en;
        logic [1:0]  sp;
        logic [1:0]  rw;
        logic [23:0] addr;
        logic [7:0]  data;
        bit          dmen;
    } ent_t;

    typedef struct {
        bit    hit;
        int    idx;
        string req;
    } exp_t;

    ent_t model_ent [4];
    bit   model_on = 1'b0;
    exp_t exp_q [$];

    always #4 clk = ~clk;

    dbg_watch_unit uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .ent_we(ent_we), .ent_sel(ent_sel), .ent_en(ent_en), .ent_space(ent_space),
        .ent_rw(ent_rw), .ent_addr(ent_addr), .ent_data(ent_data), .ent_dmen(ent_dmen),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .mem_valid(mem_valid),
        .mem_space(mem_space), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .instr_done(instr_done), .host_acc(host_acc), .cpu_hold(cpu_hold), .cpu_skip(cpu_skip),
        .code_running(code_running), .debug_access(debug_access), .hit_pulse(hit_pulse),
        .pulse_index(pulse_index), .hit_sticky(hit_sticky), .sticky_index(sticky_index)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Expected match from the requirement text, lowest entry wins.
    function automatic exp_t predict(bit is_fetch, logic [1:0] sp, bit we,
                                     logic [23:0] a, logic [7:0] d, string req);
        exp_t r;
        r.hit = 1'b0; r.idx = 0; r.req = req;
        if (!model_on) return r;
        for (int i = 0; i < 4; i++) begin
            bit m;
            if (!model_ent[i].en) m = 1'b0;
            else if (is_fetch) m = (model_ent[i].sp == 2'd0) && (model_ent[i].addr == a);
            else m = (model_ent[i].sp != 2'd0) && (model_ent[i].sp == sp)
                     && (we ? model_ent[i].rw[1] : model_ent[i].rw[0])
                     && (model_ent[i].addr == a)
                     && (!model_ent[i].dmen || model_ent[i].data == d);
            if (m && !r.hit) begin
                r.hit = 1'b1;
                r.idx = i;
            end
        end
        return r;
    endfunction

    task automatic cmd(input logic [2:0] op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        if (op == 3'd6) model_on = 1'b1;
        if (op == 3'd7) model_on = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = '0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
    endtask

    task automatic set_ent(input int i, input bit en, input logic [1:0] sp, input logic [1:0] rw,
                           input logic [23:0] a, input logic [7:0] d, input bit dmen);
        @(negedge clk);
        ent_we = 1'b1; ent_sel = 2'(i); ent_en = en; ent_space = sp; ent_rw = rw;
        ent_addr = a; ent_data = d; ent_dmen = dmen;
        model_ent[i] = '{en, sp, rw, a, d, dmen};
        @(negedge clk);
        ent_we = 1'b0;
    endtask

    // Driver: presents one access and pushes the expected outcome.
    task automatic access(input bit is_fetch, input logic [1:0] sp, input bit we,
                          input logic [23:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        exp_q.push_back(predict(is_fetch, sp, we, a, d, req));
        if (is_fetch) begin
            fetch_valid = 1'b1; fetch_addr = a;
        end else begin
            mem_valid = 1'b1; mem_space = sp; mem_we = we; mem_addr = a; mem_wdata = d;
        end
        @(negedge clk);
        fetch_valid = 1'b0; mem_valid = 1'b0;
    endtask

    // Bring the run control back to free running from any state.
    task automatic back_to_run();
        done_pulse();
        cmd(3'd2);
    endtask

    // Monitor: pops the expected item for each access and compares the pulse.
    always @(posedge clk) begin
        if (rst_n && (fetch_valid || mem_valid)) begin
            #2;
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.req, " hit_pulse"}, int'(hit_pulse), int'(e.hit));
                if (e.hit) check({e.req, " pulse_index"}, int'(pulse_index), e.idx);
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) model_ent[i] = '{1'b0, 2'd0, 2'd0, 24'd0, 8'd0, 1'b0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cpu_hold", cpu_hold, 0);
        check("R1 cpu_skip", cpu_skip, 0);
        check("R1 code_running", code_running, 1);
        check("R1 hit_sticky", hit_sticky, 0);
        check("R1 debug_access", debug_access, 0);

        // R12 unit off: no hit, HALT ignored, debug_access stays low
        set_ent(0, 1, 2'd0, 2'd0, 24'h001234, 8'h00, 0);
        access(1, 2'd0, 0, 24'h001234, 8'h00, "R12 off fetch");
        cmd(3'd1);
        done_pulse();
        check("R12 halt ignored while off", cpu_hold, 0);
        @(negedge clk); host_acc = 1'b1;
        @(negedge clk); check("R13 off access", debug_access, 0);
        host_acc = 1'b0;

        // R2 code breakpoint, R8 hold only at boundary
        cmd(3'd6);
        access(1, 2'd0, 0, 24'h001234, 8'h00, "R2 code bp");
        check("R7 sticky set", hit_sticky, 1);
        check("R7 sticky idx0", sticky_index, 0);
        @(negedge clk);
        check("R8 no hold before boundary", cpu_hold, 0);
        done_pulse();
        check("R8 hold after boundary", cpu_hold, 1);
        check("R8 code_running low", code_running, 0);
        access(1, 2'd0, 0, 24'h001235, 8'h00, "R2 other addr");

        // R7 clear, R9 run
        cmd(3'd5);
        check("R7 cleared", hit_sticky, 0);
        cmd(3'd2);
        check("R9 released", cpu_hold, 0);

        // R3 / R4 idata write-only watchpoint with data
        set_ent(1, 1, 2'd1, 2'b10, 24'h000040, 8'h5A, 1);
        access(0, 2'd1, 0, 24'h000040, 8'h5A, "R3 read on write-only");
        access(0, 2'd1, 1, 24'h000040, 8'h11, "R4 wrong data");
        access(0, 2'd1, 1, 24'h000040, 8'h5A, "R4 data match");
        check("R7 sticky idx1", sticky_index, 1);
        back_to_run();

        // R5 space selection, R4 data ignored
        set_ent(2, 1, 2'd2, 2'b11, 24'h012345, 8'h00, 0);
        access(0, 2'd3, 0, 24'h012345, 8'h00, "R5 sfr vs xdata entry");
        access(1, 2'd0, 0, 24'h012345, 8'h00, "R5 fetch vs xdata entry");
        access(0, 2'd2, 0, 24'h012345, 8'hC3, "R4 data ignored");
        check("R7 first index kept", sticky_index, 1);
        back_to_run();

        // R6 disabled entry and priority
        set_ent(3, 0, 2'd3, 2'b11, 24'h000012, 8'h00, 0);
        access(0, 2'd3, 1, 24'h000012, 8'h00, "R6 disabled");
        set_ent(3, 1, 2'd2, 2'b11, 24'h012345, 8'h00, 0);
        access(0, 2'd2, 1, 24'h012345, 8'h77, "R6 priority");
        back_to_run();

        // R7 hit in the same cycle as clear keeps status with new index
        @(negedge clk);
        exp_q.push_back(predict(1, 2'd0, 0, 24'h001234, 8'h00, "R7 hit with clear"));
        fetch_valid = 1'b1; fetch_addr = 24'h001234;
        cmd_valid = 1'b1; cmd_op = 3'd5;
        @(negedge clk);
        fetch_valid = 1'b0; cmd_valid = 1'b0;
        check("R7 set by hit with clear", hit_sticky, 1);
        check("R7 new index with clear", sticky_index, 0);
        back_to_run();

        // R8 HALT command, R10 step, R11 skip
        cmd(3'd1);
        check("R8 halt pending", cpu_hold, 0);
        done_pulse();
        check("R8 halt cmd held", cpu_hold, 1);
        cmd(3'd3);
        check("R10 step release", cpu_hold, 0);
        @(negedge clk);
        check("R10 still released", cpu_hold, 0);
        done_pulse();
        check("R10 held after one instr", cpu_hold, 1);
        cmd(3'd4);
        check("R11 skip asserted", cpu_skip, 1);
        check("R11 released", cpu_hold, 0);
        done_pulse();
        check("R11 skip dropped", cpu_skip, 0);
        check("R11 held after skip", cpu_hold, 1);

        // R13 debug access follows host
        @(negedge clk); host_acc = 1'b1;
        @(negedge clk); check("R13 follows", debug_access, 1);
        host_acc = 1'b0;
        @(negedge clk); check("R13 drops", debug_access, 0);

        // R12 OFF releases and disables
        cmd(3'd7);
        check("R12 off releases", cpu_hold, 0);
        cmd(3'd1);
        done_pulse();
        check("R12 halt ignored after off", cpu_hold, 0);
        access(1, 2'd0, 0, 24'h001234, 8'h00, "R12 off no hit");

        repeat (3) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        summary();
    end

endmodule